// File: doc/BRIEF.md
# Fine-Adjusted Bit Timing Generator

This block produces the timing skeleton of one UART direction. A programmable divisor splits the UART clock (given as a one-cycle enable, `uclk_en`) into sub-ticks. Sixteen sub-ticks make one nominal bit. An adjustment word carries a 2-bit code for each bit position of the frame. With that code the bit lasts 17 sub-ticks (stretched), 15 sub-ticks (shrunk) or the nominal 16. Spreading stretched or shrunk bits across a frame keeps the frame's total length close to the ideal value when the divisor alone cannot reach the wanted rate.

A `frame_start` pulse arms the generator. The generator then emits `os_tick` once per sub-tick, to serve as the 16x oversampling strobe, and `bit_strobe` at the end of each bit. Each `bit_strobe` comes with the updated `bit_idx`. When the configured number of bits has elapsed, the generator raises `frame_done` and stops. A transmitter and a receiver each use their own instance, with their own adjustment word.

Top module: `fine_baud_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `os_tick`, `bit_strobe` and `frame_done` are low and `bit_idx` is 0.
- R2: While a frame is running, `os_tick` pulses for one cycle after every `divisor`+1 cycles in which `uclk_en` was high.
- R3: A bit whose code is 0 lasts 16 sub-ticks. Its `bit_strobe` coincides with its 16th `os_tick`.
- R4: A bit whose code is 1 lasts 17 sub-ticks.
- R5: A bit whose code is 3 lasts 15 sub-ticks.
- R6: Code 2 behaves like code 0, so the bit lasts 16 sub-ticks.
- R7: The code for bit n is taken from `adj_word[2n+1:2n]`. Bit 0 is the start bit. `bit_idx` rises by one at each `bit_strobe` and already shows the new value in the strobe cycle.
- R8: The frame length is `frame_len` clamped to 12. The strobe that ends the last bit comes in the same cycle as a one-cycle `frame_done`. After that, no `os_tick` or `bit_strobe` occurs until the next `frame_start`.
- R9: `frame_start` restarts the sub-tick count, the bit count and the frame length at zero, even in the middle of a frame. It takes priority over a sub-tick or bit end that falls in the same cycle.
- R10: Cycles with `uclk_en` low do not advance any count, and `os_tick` stays low in the cycle after them.
- R11: With `divisor` 0 and `uclk_en` always high, a nominal bit takes 16 clock cycles and a shrunk bit takes 15.
- R12: A `frame_start` with `frame_len` 0 gives a `frame_done` pulse in the next cycle, with no `os_tick` and no `bit_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uclk_en | input | 1 | One-cycle enable marking each UART clock tick |
| divisor | input | DIV_W | Sub-tick length minus one, in UART clock ticks |
| adj_word | input | 2*MAX_BITS | 2-bit per-bit width code: 0 nominal, 1 stretch, 2 nominal, 3 shrink |
| frame_start | input | 1 | Starts a new frame from bit 0 |
| frame_len | input | IDX_W | Number of bits in the frame (clamped to MAX_BITS) |
| os_tick | output | 1 | 16x oversampling strobe, one per sub-tick |
| bit_strobe | output | 1 | End of a bit |
| bit_idx | output | IDX_W | Index of the current bit; equals the frame length after the last bit |
| frame_done | output | 1 | One-cycle pulse when the frame ends |

## Verification
Two situations can land in the same cycle.

- **Last bit and frame end.** The strobe that ends the last bit and `frame_done` share a cycle. The scoreboard marks the final expected item, and that item is accepted only if `frame_done` is high in the same cycle as its strobe.
- **Restart and a sub-tick.** A `frame_start` can coincide with a sub-tick event. With `divisor` 0 and `uclk_en` always high, every cycle is a sub-tick event, so a restart issued mid-frame always collides with one. The new frame's strobes are then judged by their UART-tick and sub-tick offsets from the restart edge.

Random gaps in `uclk_en` move every expected offset. The scoreboard therefore counts only enabled cycles.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;
  localparam int SUB_W = 5;

  typedef enum logic [1:0] {
    ADJ_NOM    = 2'd0,
    ADJ_WIDE   = 2'd1,
    ADJ_SPARE  = 2'd2,
    ADJ_NARROW = 2'd3
  } adj_code_e;

  // index of the final sub-tick of a bit for a given code
  function automatic logic [SUB_W-1:0] slot_last(input adj_code_e code);
    case (code)
      ADJ_WIDE:   return SUB_W'(16);
      ADJ_NARROW: return SUB_W'(14);
      default:    return SUB_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/fbg_prescale.sv
`timescale 1ns/1ps
module fbg_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             sub_evt
);
  logic [DIV_W-1:0] cnt;

  assign sub_evt = run && (cnt >= divisor);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= sub_evt ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbg_bit_slot.sv
`timescale 1ns/1ps
module fbg_bit_slot
  import fbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  logic      sub_evt,
  input  adj_code_e code,
  output logic      bit_evt
);
  logic [SUB_W-1:0] cnt;
  logic [SUB_W-1:0] last;

  assign last    = slot_last(code);
  assign bit_evt = sub_evt && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (sub_evt) begin
      cnt <= bit_evt ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbg_frame_seq.sv
`timescale 1ns/1ps
module fbg_frame_seq
  import fbg_pkg::*;
#(
  parameter int MAX_BITS = 12,
  parameter int IDX_W    = 4,
  parameter int ADJ_W    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [IDX_W-1:0] frame_len,
  input  logic [ADJ_W-1:0] adj_word,
  input  logic             sub_evt,
  input  logic             bit_evt,
  output logic             active,
  output adj_code_e        cur_code,
  output logic [IDX_W-1:0] bit_idx,
  output logic             os_tick,
  output logic             bit_strobe,
  output logic             frame_done
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(MAX_BITS);

  adj_code_e        codes [MAX_BITS];
  logic [IDX_W-1:0] eff_len;
  logic [IDX_W-1:0] len_q;
  logic [IDX_W-1:0] next_idx;

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_code
    assign codes[g] = adj_code_e'(adj_word[2*g +: 2]);
  end

  always_comb begin
    cur_code = ADJ_NOM;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (bit_idx == IDX_W'(i)) cur_code = codes[i];
    end
  end

  assign eff_len  = (frame_len > MAX_IDX) ? MAX_IDX : frame_len;
  assign next_idx = bit_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      bit_idx    <= '0;
      len_q      <= '0;
      os_tick    <= 1'b0;
      bit_strobe <= 1'b0;
      frame_done <= 1'b0;
    end else if (frame_start) begin
      active     <= (eff_len != '0);
      bit_idx    <= '0;
      len_q      <= eff_len;
      os_tick    <= 1'b0;
      bit_strobe <= 1'b0;
      frame_done <= (eff_len == '0);
    end else begin
      os_tick    <= sub_evt;
      bit_strobe <= bit_evt;
      frame_done <= 1'b0;
      if (bit_evt) begin
        bit_idx <= next_idx;
        if (next_idx == len_q) begin
          active     <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fine_baud_gen.sv
`timescale 1ns/1ps
module fine_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int MAX_BITS = 12,
  localparam int IDX_W   = $clog2(MAX_BITS + 1),
  localparam int ADJ_W   = 2 * MAX_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             uclk_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [ADJ_W-1:0] adj_word,
  input  logic             frame_start,
  input  logic [IDX_W-1:0] frame_len,
  output logic             os_tick,
  output logic             bit_strobe,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_done
);
  logic      active;
  logic      run;
  logic      sub_evt;
  logic      bit_evt;
  adj_code_e cur_code;

  assign run = active && uclk_en;

  fbg_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_start),
    .run     (run),
    .divisor (divisor),
    .sub_evt (sub_evt)
  );

  fbg_bit_slot u_slot (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_start),
    .sub_evt (sub_evt),
    .code    (cur_code),
    .bit_evt (bit_evt)
  );

  fbg_frame_seq #(
    .MAX_BITS (MAX_BITS),
    .IDX_W    (IDX_W),
    .ADJ_W    (ADJ_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_len   (frame_len),
    .adj_word    (adj_word),
    .sub_evt     (sub_evt),
    .bit_evt     (bit_evt),
    .active      (active),
    .cur_code    (cur_code),
    .bit_idx     (bit_idx),
    .os_tick     (os_tick),
    .bit_strobe  (bit_strobe),
    .frame_done  (frame_done)
  );
endmodule

// File: rtl/fine_baud_gen_chk.sv
`timescale 1ns/1ps
module fine_baud_gen_chk #(
  parameter int MAX_BITS = 12,
  parameter int IDX_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             uclk_en,
  input logic             frame_start,
  input logic             active,
  input logic             os_tick,
  input logic             bit_strobe,
  input logic [IDX_W-1:0] bit_idx,
  input logic             frame_done
);
  // R3: a bit ends only on a sub-tick
  p_strobe_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> os_tick);

  // R7: index steps by one per bit
  p_idx_step_r7: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> (bit_idx == IDX_W'($past(bit_idx) + 1'b1)));

  // R8 / R12: done only with the last strobe or straight after an empty start
  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (bit_strobe || $past(frame_start)));

  // R8: nothing moves while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(active) && !$past(frame_start)) |-> (!os_tick && !bit_strobe));

  // R8: index never passes the maximum frame length
  p_idx_bound_r8: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= IDX_W'(MAX_BITS));

  // R9: restart clears the frame state
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    $past(frame_start) |-> (bit_idx == '0 && !bit_strobe && !os_tick));

  // R10: a disabled UART clock cycle yields no sub-tick
  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(uclk_en) |-> !os_tick);
endmodule

bind fine_baud_gen fine_baud_gen_chk #(
  .MAX_BITS (MAX_BITS),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .uclk_en     (uclk_en),
  .frame_start (frame_start),
  .active      (active),
  .os_tick     (os_tick),
  .bit_strobe  (bit_strobe),
  .bit_idx     (bit_idx),
  .frame_done  (frame_done)
);

// File: tb/fine_baud_gen_bench.sv
`timescale 1ns/1ps
module fine_baud_gen_bench;
  localparam int DIV_W    = 12;
  localparam int MAX_BITS = 12;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);
  localparam int ADJ_W    = 2 * MAX_BITS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             uclk_en = 1'b1;
  logic [DIV_W-1:0] divisor = '0;
  logic [ADJ_W-1:0] adj_word = '0;
  logic             frame_start = 1'b0;
  logic [IDX_W-1:0] frame_len = '0;
  logic             os_tick;
  logic             bit_strobe;
  logic [IDX_W-1:0] bit_idx;
  logic             frame_done;

  typedef struct {
    int    uoff;
    int    soff;
    int    idx;
    bit    last;
    string req;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          failures = 0;
  int          ucnt = 0;
  int          scnt = 0;
  int          done_seen = 0;
  bit          gap_en = 1'b0;
  bit          zero_done_ok = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  fine_baud_gen #(.DIV_W(DIV_W), .MAX_BITS(MAX_BITS)) u_fine_baud_gen (
    .clk         (clk),
    .rst         (rst),
    .uclk_en     (uclk_en),
    .divisor     (divisor),
    .adj_word    (adj_word),
    .frame_start (frame_start),
    .frame_len   (frame_len),
    .os_tick     (os_tick),
    .bit_strobe  (bit_strobe),
    .bit_idx     (bit_idx),
    .frame_done  (frame_done)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // UART clock enable: steady or gappy pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    uclk_en = gap_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // enabled-tick counter since the last frame start
  always @(posedge clk) begin
    if (frame_start) begin
      ucnt <= 0;
      scnt <= 0;
    end else if (uclk_en) begin
      ucnt <= ucnt + 1;
    end
  end

  // monitor: pops the scoreboard on every bit end
  always @(negedge clk) begin
    if (!rst) begin
      if (os_tick) scnt = scnt + 1;
      if (frame_done) done_seen++;
      if (bit_strobe) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "strobe with nothing expected", int'(bit_idx), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(ucnt == e.uoff, e.req, "uart ticks to bit end", ucnt, e.uoff);
          check(scnt == e.soff, e.req, "sub-ticks to bit end", scnt, e.soff);
          check(int'(bit_idx) == e.idx, "R7", "bit index", int'(bit_idx), e.idx);
          check(frame_done == e.last, "R8", "done with last strobe",
                int'(frame_done), int'(e.last));
        end
      end else if (frame_done) begin
        check(zero_done_ok, "R12", "done without strobe", 1, int'(zero_done_ok));
        check(scnt == 0, "R12", "no sub-tick in empty frame", scnt, 0);
      end
    end
  end

  // driver: starts a frame, then loads the scoreboard
  task automatic run_frame(input int d, input logic [ADJ_W-1:0] adj,
                           input int len, input bit gaps, input string req);
    int eff;
    int cum;
    eff = (len > MAX_BITS) ? MAX_BITS : len;
    cum = 0;
    @(posedge clk); #1;
    gap_en       = gaps;
    divisor      = DIV_W'(d);
    adj_word     = adj;
    frame_len    = IDX_W'(len);
    zero_done_ok = (eff == 0);
    frame_start  = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
    q.delete();
    for (int n = 0; n < eff; n++) begin
      logic [1:0] c;
      int l;
      c = adj[2*n +: 2];
      l = (c == 2'd1) ? 17 : ((c == 2'd3) ? 15 : 16);
      cum += l;
      q.push_back('{cum * (d + 1), cum, n + 1, (n == eff - 1), req});
    end
  endtask

  task automatic wait_frame(input string req);
    int d0;
    int guard;
    int s0;
    d0 = done_seen;
    guard = 0;
    while (done_seen == d0 && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    check(done_seen != d0, req, "frame finished", done_seen - d0, 1);
    check(q.size() == 0, req, "scoreboard drained", q.size(), 0);
    s0 = scnt;
    repeat (200) @(posedge clk);
    check(scnt == s0, "R8", "no sub-tick while idle", scnt, s0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(!os_tick && !bit_strobe && !frame_done && bit_idx == '0,
          "R1", "outputs during reset", int'(os_tick | bit_strobe | frame_done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!os_tick && !bit_strobe && !frame_done && bit_idx == '0,
          "R1", "outputs after reset", int'(bit_idx), 0);

    run_frame(0, 24'h000000, 10, 1'b0, "R11"); wait_frame("R3");
    run_frame(0, 24'hFFFFFF, 12, 1'b0, "R11"); wait_frame("R5");
    run_frame(2, 24'h555555, 12, 1'b0, "R4");  wait_frame("R4");
    run_frame(1, 24'hFFFFFF, 12, 1'b0, "R5");  wait_frame("R5");
    run_frame(3, 24'hAAAAAA, 7,  1'b0, "R6");  wait_frame("R6");
    run_frame(1, 24'h9C3E71, 12, 1'b1, "R10"); wait_frame("R7");
    run_frame(2, 24'h1D2B47, 9,  1'b1, "R2");  wait_frame("R2");
    run_frame(0, 24'h00C300, 15, 1'b0, "R8");  wait_frame("R8");
    run_frame(1, 24'h555555, 0,  1'b0, "R12"); wait_frame("R12");

    // restart mid-frame; with divisor 0 every cycle carries a sub-tick
    run_frame(0, 24'h000000, 12, 1'b0, "R9");
    repeat (70) @(posedge clk);
    run_frame(0, 24'hD7F31C, 6, 1'b0, "R9");
    wait_frame("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule